// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits beside a shared memory and holds one reservation per processor for load-exclusive / store-exclusive pairs. A load-exclusive to a region marked shared records the address granule the processor reserved. A load-exclusive to a non-shared region records only that the processor has a reservation outstanding, with no address kept. A store-exclusive is then granted or refused. A shared store-exclusive needs a matching granule. A non-shared one needs only an outstanding reservation. The monitor answers with a store-enable and a pass/fail status.

Each processor has its own request lane, and every lane may present one request per cycle. Each lane carries an operation, a byte address, a shared attribute and an access size. A granted shared store-exclusive removes every reservation on its granule, so two competing lock claims can never both succeed. A plain store removes them in the same way. When two lanes race for one granule in the same cycle, the lower lane index wins. All requests in a cycle are judged against the reservation state held at the start of that cycle. Responses are registered and appear one cycle after the request, on a per-lane valid strobe.

Top module: `excl_mon`

## Requirements
- R1: After synchronous reset no lane holds a reservation and no response strobe is raised; a store-exclusive issued with no prior load-exclusive fails.
- R2: A shared load-exclusive followed by a shared store-exclusive to the same granule from the same lane returns store-enable 1 and status 0 and consumes the reservation, so that a repeated store-exclusive fails.
- R3: A non-shared load-exclusive followed by a non-shared store-exclusive from the same lane succeeds, and a second non-shared store-exclusive then fails.
- R4: A failed store-exclusive returns status 1 with store-enable 0; store-enable is never 1 while status is 1.
- R5: A granted shared store-exclusive clears every other lane's shared reservation on that granule.
- R6: When several lanes make eligible shared store-exclusives to one granule in the same cycle, only the lowest lane index succeeds. Lanes working on other granules are not affected.
- R7: A plain store to any byte of a reserved granule (granule size GRAN_BYTES, default 8) clears every shared reservation on that granule, including the storing lane's own.
- R8: A plain store to a different granule leaves a shared reservation intact.
- R9: A plain store whose bytes span two granules clears reservations on both granules; it covers 2^size bytes from its address.
- R10: Each valid request gets rsp_valid exactly one cycle later on its lane. The op encoding is 00 load, 01 store, 10 load-exclusive and 11 store-exclusive. Loads and load-exclusives return store-enable 0 and status 0. Plain stores return store-enable 1 and status 0.
- R11: A load-exclusive issued in the same cycle as another lane's plain store to that granule sets the reservation.
- R12: A successful non-shared store-exclusive of one lane leaves the reservations of other lanes untouched.
- R13: The size code (0 byte, 1 halfword, 2 word, 3 doubleword) does not change the outcome of a naturally aligned exclusive pair inside one granule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_PROC | Per-lane request strobe |
| req_op | input | 2*N_PROC | Per-lane operation code |
| req_addr | input | ADDR_W*N_PROC | Per-lane byte address |
| req_shared | input | N_PROC | Per-lane shared attribute of the address |
| req_size | input | 2*N_PROC | Per-lane access size code |
| rsp_valid | output | N_PROC | Response strobe, one cycle after the request |
| rsp_store_en | output | N_PROC | Memory write may proceed |
| rsp_status | output | N_PROC | 0 on pass, 1 on a refused store-exclusive |

## Verification
The hardest situations to reach are those where lanes collide within a single cycle. One is two lanes claiming one granule at once. Another is a load-exclusive that meets another lane's clearing store on the same edge. Neither can arise from requests issued one after another. The driver therefore stages requests on several lanes and releases them together in one cycle. The expected outcome of each lane is queued in lane order. The monitor then matches each response against its lane and against the cycle of its request.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'b00,
    OP_STORE = 2'b01,
    OP_LDEX = 2'b10,
    OP_STEX = 2'b11
  } mon_op_e;
endpackage

// File: rtl/excl_mon_entry.sv
module excl_mon_entry #(
  parameter int N_PROC = 4,
  parameter int GW = 29
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_i,
  input  logic                 set_shared_i,
  input  logic [GW-1:0]        set_gran_i,
  input  logic                 own_clr_i,
  input  logic [N_PROC-1:0]    clr_vld_i,
  input  logic [N_PROC*GW-1:0] clr_lo_i,
  input  logic [N_PROC*GW-1:0] clr_hi_i,
  output logic                 vld_o,
  output logic                 shared_o,
  output logic [GW-1:0]        gran_o
);
  logic          vld_q, shr_q;
  logic [GW-1:0] gran_q;
  logic          snoop_hit;

  // any clearing write from any lane touching the held granule
  always_comb begin
    snoop_hit = 1'b0;
    for (int k = 0; k < N_PROC; k++) begin
      if (clr_vld_i[k] &&
          (clr_lo_i[k*GW +: GW] == gran_q || clr_hi_i[k*GW +: GW] == gran_q))
        snoop_hit = 1'b1;
    end
  end

  // a new reservation outranks any clear landing on the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      shr_q  <= 1'b0;
      gran_q <= '0;
    end else if (set_i) begin
      vld_q  <= 1'b1;
      shr_q  <= set_shared_i;
      gran_q <= set_gran_i;
    end else if (own_clr_i || (snoop_hit && shr_q)) begin
      vld_q  <= 1'b0;
    end
  end

  assign vld_o    = vld_q;
  assign shared_o = shr_q;
  assign gran_o   = gran_q;

  p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !vld_q);

  p_set_holds_r11: assert property (@(posedge clk) disable iff (rst)
    set_i |=> (vld_q && gran_q == $past(set_gran_i)));
endmodule

// File: rtl/excl_mon_arb.sv
module excl_mon_arb #(
  parameter int N_PROC = 4,
  parameter int GW = 29
) (
  input  logic [N_PROC-1:0]    elig_i,
  input  logic [N_PROC*GW-1:0] gran_i,
  output logic [N_PROC-1:0]    win_o
);
  for (genvar i = 0; i < N_PROC; i++) begin : g_lane
    logic beaten;
    always_comb begin
      beaten = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (elig_i[j] && gran_i[j*GW +: GW] == gran_i[i*GW +: GW])
          beaten = 1'b1;
      end
    end
    assign win_o[i] = elig_i[i] && !beaten;
  end
endmodule

// File: rtl/excl_mon.sv
module excl_mon
  import excl_mon_pkg::*;
#(
  parameter int N_PROC = 4,
  parameter int ADDR_W = 32,
  parameter int GRAN_BYTES = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_PROC-1:0]        req_valid,
  input  logic [2*N_PROC-1:0]      req_op,
  input  logic [ADDR_W*N_PROC-1:0] req_addr,
  input  logic [N_PROC-1:0]        req_shared,
  input  logic [2*N_PROC-1:0]      req_size,
  output logic [N_PROC-1:0]        rsp_valid,
  output logic [N_PROC-1:0]        rsp_store_en,
  output logic [N_PROC-1:0]        rsp_status
);
  localparam int GRAN_LSB = $clog2(GRAN_BYTES);
  localparam int GW = ADDR_W - GRAN_LSB;

  logic [N_PROC-1:0]    is_ldex, is_stex, is_st;
  logic [N_PROC*GW-1:0] gran_lo, gran_hi, ent_gran;
  logic [N_PROC-1:0]    ent_vld, ent_shr;
  logic [N_PROC-1:0]    ns_ok, elig, win, st_ok, clr_vld;

  for (genvar i = 0; i < N_PROC; i++) begin : g_lane
    mon_op_e           op_i;
    logic [ADDR_W-1:0] addr_i, last_b;

    assign op_i   = mon_op_e'(req_op[2*i +: 2]);
    assign addr_i = req_addr[i*ADDR_W +: ADDR_W];
    assign last_b = addr_i + ((ADDR_W'(1) << req_size[2*i +: 2]) - ADDR_W'(1));

    assign gran_lo[i*GW +: GW] = GW'(addr_i >> GRAN_LSB);
    assign gran_hi[i*GW +: GW] = GW'(last_b >> GRAN_LSB);

    assign is_ldex[i] = req_valid[i] && op_i == OP_LDEX;
    assign is_stex[i] = req_valid[i] && op_i == OP_STEX;
    assign is_st[i]   = req_valid[i] && op_i == OP_STORE;

    // address-less mode: any outstanding reservation suffices
    assign ns_ok[i] = is_stex[i] && !req_shared[i] && ent_vld[i];
    // address-tagged mode: granule must match the held tag
    assign elig[i]  = is_stex[i] && req_shared[i] && ent_vld[i] && ent_shr[i] &&
                      ent_gran[i*GW +: GW] == gran_lo[i*GW +: GW];
    assign st_ok[i]   = ns_ok[i] || win[i];
    assign clr_vld[i] = win[i] || is_st[i];

    excl_mon_entry #(.N_PROC(N_PROC), .GW(GW)) u_entry (
      .clk          (clk),
      .rst          (rst),
      .set_i        (is_ldex[i]),
      .set_shared_i (req_shared[i]),
      .set_gran_i   (gran_lo[i*GW +: GW]),
      .own_clr_i    (st_ok[i]),
      .clr_vld_i    (clr_vld),
      .clr_lo_i     (gran_lo),
      .clr_hi_i     (gran_hi),
      .vld_o        (ent_vld[i]),
      .shared_o     (ent_shr[i]),
      .gran_o       (ent_gran[i*GW +: GW])
    );

    p_fail_no_store_r4: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid[i] && rsp_status[i]) |-> !rsp_store_en[i]);

    p_rsp_after_req_r10: assert property (@(posedge clk) disable iff (rst)
      rsp_valid[i] |-> $past(req_valid[i]));

    p_grant_needs_tag_r2: assert property (@(posedge clk) disable iff (rst)
      ($past(is_stex[i]) && rsp_store_en[i]) |-> $past(ent_vld[i]));
  end

  excl_mon_arb #(.N_PROC(N_PROC), .GW(GW)) u_arb (
    .elig_i (elig),
    .gran_i (gran_lo),
    .win_o  (win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= '0;
      rsp_store_en <= '0;
      rsp_status   <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_store_en <= is_st | st_ok;
      rsp_status   <= is_stex & ~st_ok;
    end
  end

  for (genvar a = 0; a < N_PROC; a++) begin : g_pa
    for (genvar b = a + 1; b < N_PROC; b++) begin : g_pb
      logic same_claim;
      assign same_claim = is_stex[a] && is_stex[b] && req_shared[a] && req_shared[b] &&
                          gran_lo[a*GW +: GW] == gran_lo[b*GW +: GW];
      p_one_winner_r6: assert property (@(posedge clk) disable iff (rst)
        $past(same_claim) |-> !(rsp_store_en[a] && rsp_store_en[b]));
    end
  end
endmodule

// File: tb/excl_mon_tb_top.sv
module excl_mon_tb_top;
  localparam int N  = 4;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]    req_valid = '0;
  logic [2*N-1:0]  req_op = '0;
  logic [AW*N-1:0] req_addr = '0;
  logic [N-1:0]    req_shared = '0;
  logic [2*N-1:0]  req_size = '0;
  logic [N-1:0]    rsp_valid, rsp_store_en, rsp_status;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  typedef struct {
    int    p;
    bit    se;
    bit    st;
    int    cyc;
    string rq;
  } exp_t;
  exp_t q[$];
  exp_t stage[N];
  bit   staged[N];

  localparam logic [1:0] LD = 2'b00, ST = 2'b01, LX = 2'b10, SX = 2'b11;

  excl_mon #(.N_PROC(N), .ADDR_W(AW), .GRAN_BYTES(8)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_shared(req_shared), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_store_en(rsp_store_en), .rsp_status(rsp_status)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic put(input int p, input logic [1:0] op, input logic [31:0] a,
                     input bit sh, input logic [1:0] sz, input bit se, input bit st,
                     input string rq);
    req_valid[p]          = 1'b1;
    req_op[2*p +: 2]      = op;
    req_addr[AW*p +: AW]  = a;
    req_shared[p]         = sh;
    req_size[2*p +: 2]    = sz;
    stage[p]  = '{p: p, se: se, st: st, cyc: 0, rq: rq};
    staged[p] = 1'b1;
  endtask

  // releases the staged lanes together for one cycle, expectations in lane order
  task automatic fire();
    for (int p = 0; p < N; p++) begin
      if (staged[p]) begin
        stage[p].cyc = cyc;
        q.push_back(stage[p]);
        staged[p] = 1'b0;
      end
    end
    @(posedge clk);
    #2;
    req_valid = '0;
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (!rst) begin
      for (int p = 0; p < N; p++) begin
        if (rsp_valid[p]) begin
          total++;
          if (q.size() == 0) begin
            bad++;
            $display("FAIL R10 lane %0d: response actual=1 expected=none", p);
          end else begin
            e = q.pop_front();
            if (e.p != p || e.cyc + 1 != cyc || rsp_store_en[p] !== e.se ||
                rsp_status[p] !== e.st) begin
              bad++;
              $display("FAIL %s lane %0d cyc %0d: actual se=%0b st=%0b expected lane %0d cyc %0d se=%0b st=%0b",
                       e.rq, p, cyc, rsp_store_en[p], rsp_status[p], e.p, e.cyc + 1, e.se, e.st);
            end
          end
        end
      end
      while (q.size() > 0 && q[0].cyc + 1 < cyc) begin
        e = q.pop_front();
        total++;
        bad++;
        $display("FAIL %s lane %0d: response actual=none expected se=%0b st=%0b", e.rq, e.p, e.se, e.st);
      end
    end
  end

  initial begin
    #(20 * 5000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [31:0] A = 32'h1000, B = 32'h2000;

  initial begin
    for (int p = 0; p < N; p++) staged[p] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (rsp_valid !== '0) begin
      bad++;
      $display("FAIL R1 reset: rsp_valid actual=%b expected=0000", rsp_valid);
    end
    @(posedge clk);
    #2 rst = 1'b0;
    @(posedge clk);
    #2;

    // R1 / R4: no reservation after reset
    put(0, SX, A, 1, 2, 0, 1, "R1 shared stex after reset");
    put(1, SX, 32'h3000, 0, 2, 0, 1, "R4 nonshared stex no tag");
    fire();
    // R10: plain load and plain store answers
    put(2, LD, A, 1, 2, 0, 0, "R10 plain load");
    put(3, ST, 32'h5000, 1, 2, 1, 0, "R10 plain store");
    fire();
    // R2
    put(0, LX, A, 1, 2, 0, 0, "R10 ldex answer");
    fire();
    put(0, SX, A, 1, 2, 1, 0, "R2 shared grant");
    fire();
    put(0, SX, A, 1, 2, 0, 1, "R2 reservation consumed");
    fire();
    // R3
    put(1, LX, 32'h3000, 0, 2, 0, 0, "R3 ns ldex");
    fire();
    put(1, SX, 32'h3000, 0, 2, 1, 0, "R3 ns grant");
    fire();
    put(1, SX, 32'h3000, 0, 2, 0, 1, "R3 ns consumed");
    fire();
    // R12
    put(0, LX, 32'h3000, 0, 2, 0, 0, "R12 ldex p0");
    put(1, LX, 32'h3040, 0, 2, 0, 0, "R12 ldex p1");
    fire();
    put(0, SX, 32'h3000, 0, 2, 1, 0, "R12 p0 grant");
    fire();
    put(1, SX, 32'h3040, 0, 2, 1, 0, "R12 p1 still holds");
    fire();
    // R5
    put(1, LX, A, 1, 2, 0, 0, "R5 ldex p1");
    fire();
    put(0, LX, A, 1, 2, 0, 0, "R5 ldex p0");
    fire();
    put(0, SX, A, 1, 2, 1, 0, "R5 p0 grant");
    fire();
    put(1, SX, A, 1, 2, 0, 1, "R5 p1 cleared");
    fire();
    // R6: same-cycle race, lane 3 on its own granule
    put(1, LX, B, 1, 2, 0, 0, "R6 ldex p1");
    put(2, LX, B, 1, 2, 0, 0, "R6 ldex p2");
    put(3, LX, B + 32'h40, 1, 2, 0, 0, "R6 ldex p3");
    fire();
    put(1, SX, B, 1, 2, 1, 0, "R6 lower lane wins");
    put(2, SX, B, 1, 2, 0, 1, "R6 higher lane loses");
    put(3, SX, B + 32'h40, 1, 2, 1, 0, "R6 other granule unaffected");
    fire();
    // R7
    put(0, LX, A, 1, 2, 0, 0, "R7 ldex");
    fire();
    put(3, ST, A + 32'h7, 1, 0, 1, 0, "R7 plain store");
    fire();
    put(0, SX, A, 1, 2, 0, 1, "R7 tag cleared by store");
    fire();
    // R8
    put(0, LX, A, 1, 2, 0, 0, "R8 ldex");
    fire();
    put(3, ST, A + 32'h8, 1, 0, 1, 0, "R8 store other granule");
    fire();
    put(0, SX, A, 1, 2, 1, 0, "R8 tag kept");
    fire();
    // R9
    put(0, LX, A + 32'h8, 1, 2, 0, 0, "R9 ldex");
    fire();
    put(3, ST, A + 32'h6, 1, 2, 1, 0, "R9 spanning store");
    fire();
    put(0, SX, A + 32'h8, 1, 2, 0, 1, "R9 second granule cleared");
    fire();
    // R11
    put(0, LX, A, 1, 2, 0, 0, "R11 ldex");
    put(1, ST, A, 1, 2, 1, 0, "R11 same-cycle store");
    fire();
    put(0, SX, A, 1, 2, 1, 0, "R11 ldex kept");
    fire();
    // R13
    put(2, LX, 32'h4000, 1, 3, 0, 0, "R13 dword ldex");
    fire();
    put(2, SX, 32'h4000, 1, 3, 1, 0, "R13 dword grant");
    fire();
    put(2, LX, 32'h4003, 1, 0, 0, 0, "R13 byte ldex");
    fire();
    put(2, SX, 32'h4003, 1, 0, 1, 0, "R13 byte grant");
    fire();

    repeat (4) @(posedge clk);
    @(negedge clk);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R10 drain: pending actual=%0d expected=0", q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule